// File: doc/BRIEF.md
# Out-of-Order Micro-op Window with Oldest-First Selection

This block is the in-flight window of an out-of-order core model. Each cycle it can accept up to `WIDTH` renamed micro-ops at its tail, pick up to `WIDTH` of the stored micro-ops to begin execution, and retire up to `WIDTH` finished micro-ops from its head. The entries form a circular queue of `DEPTH` slots. Each slot holds three source tags, two destination tags, a load flag, a store flag, a memory address, a wrap-safe age stamp, an issued flag and the cycle in which its result is due.

Operand readiness comes from an external scoreboard as one bit per physical register. The block reports each selected micro-op's destination tags and latency so that the scoreboard can schedule its wakeup. It also reports the destination tags of each retiring micro-op so that they can be released. Within a cycle, retirement is evaluated first, then selection, then acceptance. A slot freed by retirement can be refilled in the same cycle. A micro-op accepted in a cycle is not visible to selection until the next cycle.

A parameter picks how a load is held back by older stores: never, by any older store that is not yet complete, or only by an older incomplete store to the identical address.

Top module: `uop_window`

## Requirements
- R1: The window never holds more than `DEPTH` micro-ops. Input slot i is granted only if slots 0..i are all valid and i is smaller than the free count. The free count includes slots released by retirement in the same cycle. When the window is full and nothing retires, no slot is granted.
- R2: Retirement takes up to `WIDTH` micro-ops in order from the head. It stops at the first one that is not complete, even if younger micro-ops are complete.
- R3: A micro-op selected in cycle t is complete from cycle t+1 if it is not a load, and from cycle t+3 if it is a load. A micro-op counts as complete only once it has been selected and that cycle has been reached. `iss_lat` carries 3 for a load and 1 otherwise.
- R4: Selection picks at most `WIDTH` unselected, eligible micro-ops, taking them from oldest to youngest. Output slot 0 carries the oldest one chosen, and the chosen micro-ops are packed from slot 0 upwards.
- R5: A micro-op is eligible only if every source whose valid bit is set has `preg_ready[tag]` equal to 1. Sources whose valid bit is clear are ignored.
- R6: A micro-op accepted in cycle t is never selected before cycle t+1.
- R7: With `MEM_MODE`=0, stores never hold back a load.
- R8: With `MEM_MODE`=1, a load is not eligible while any older store in the window is not yet complete.
- R9: With `MEM_MODE`=2, a load is held back only by an older incomplete store whose address equals the load's address.
- R10: The older-than test is correct when the age stamps wrap past zero, for example a store stamped 7 followed by a load stamped 0 with a 3-bit stamp.
- R11: After reset the window is empty, nothing is selected or retired, and input slots are granted according to R1.
- R12: `iss_dst`/`iss_dst_vld` and `cmt_dst`/`cmt_dst_vld` carry, for each output slot, the destination tags and valid bits that were stored with that micro-op. Destination d of slot i is at bits `[(2*i+d)*PTAG_W +: PTAG_W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enq_valid | input | WIDTH | Incoming micro-op valid, per slot |
| enq_src | input | WIDTH*3*PTAG_W | Source tags. Slot i, source s is at `(3*i+s)*PTAG_W` |
| enq_src_vld | input | WIDTH*3 | Source valid bits, bit 3*i+s |
| enq_dst | input | WIDTH*2*PTAG_W | Destination tags. Slot i, destination d is at `(2*i+d)*PTAG_W` |
| enq_dst_vld | input | WIDTH*2 | Destination valid bits, bit 2*i+d |
| enq_load | input | WIDTH | Micro-op is a load |
| enq_store | input | WIDTH | Micro-op is a store |
| enq_addr | input | WIDTH*ADDR_W | Memory address, per slot |
| preg_ready | input | 2**PTAG_W | Scoreboard ready bit per physical register |
| enq_grant | output | WIDTH | Incoming slot accepted this cycle |
| iss_valid | output | WIDTH | Selected micro-op valid, per output slot |
| iss_dst | output | WIDTH*2*PTAG_W | Destination tags of the selected micro-ops |
| iss_dst_vld | output | WIDTH*2 | Destination valid bits of the selected micro-ops |
| iss_lat | output | WIDTH*$clog2(LOAD_LAT+1) | Latency of each selected micro-op |
| cmt_valid | output | WIDTH | Retiring micro-op valid, per output slot |
| cmt_dst | output | WIDTH*2*PTAG_W | Destination tags of the retiring micro-ops |
| cmt_dst_vld | output | WIDTH*2 | Destination valid bits of the retiring micro-ops |

## Verification
A cycle table drives a dependency pattern through a small window. In that pattern one operand is late while younger micro-ops are ready, which separates true oldest-first packing from in-order stalling. The same table fills the window while retirement frees slots in the same cycle, which separates same-cycle refill from waiting a cycle. A load/store pattern runs on three instances, one per memory rule, all fed the same inputs. The pattern has one store whose operand is held back, one load to the same address as that store and one load to a different address. The three instances then issue the loads in visibly different cycles. Those stamps straddle the age wrap, so a naive magnitude compare would mis-order them. A directed full-window case and an idle reset case cover the grant boundary.

// File: rtl/uop_window.sv
module uop_window #(
  parameter int DEPTH    = 8,
  parameter int WIDTH    = 2,
  parameter int PTAG_W   = 6,
  parameter int ADDR_W   = 32,
  parameter int CYC_W    = 16,
  parameter int LOAD_LAT = 3,
  parameter int MEM_MODE = 2
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [WIDTH-1:0]                      enq_valid,
  input  logic [WIDTH*3*PTAG_W-1:0]             enq_src,
  input  logic [WIDTH*3-1:0]                    enq_src_vld,
  input  logic [WIDTH*2*PTAG_W-1:0]             enq_dst,
  input  logic [WIDTH*2-1:0]                    enq_dst_vld,
  input  logic [WIDTH-1:0]                      enq_load,
  input  logic [WIDTH-1:0]                      enq_store,
  input  logic [WIDTH*ADDR_W-1:0]               enq_addr,
  input  logic [(1<<PTAG_W)-1:0]                preg_ready,
  output logic [WIDTH-1:0]                      enq_grant,
  output logic [WIDTH-1:0]                      iss_valid,
  output logic [WIDTH*2*PTAG_W-1:0]             iss_dst,
  output logic [WIDTH*2-1:0]                    iss_dst_vld,
  output logic [WIDTH*$clog2(LOAD_LAT+1)-1:0]   iss_lat,
  output logic [WIDTH-1:0]                      cmt_valid,
  output logic [WIDTH*2*PTAG_W-1:0]             cmt_dst,
  output logic [WIDTH*2-1:0]                    cmt_dst_vld
);
  // DEPTH must be a power of two: slot indices wrap by truncation.
  localparam int IDX_W = $clog2(DEPTH);
  localparam int AGE_W = IDX_W + 1;
  localparam int LAT_W = $clog2(LOAD_LAT + 1);

  logic [IDX_W-1:0]        head;
  logic [AGE_W-1:0]        tail_age;
  logic [AGE_W-1:0]        cnt;
  logic [CYC_W-1:0]        cyc;

  logic [DEPTH-1:0]        e_vld, e_iss, e_ld, e_st;
  logic [3*PTAG_W-1:0]     e_src  [DEPTH];
  logic [2:0]              e_sv   [DEPTH];
  logic [2*PTAG_W-1:0]     e_dst  [DEPTH];
  logic [1:0]              e_dv   [DEPTH];
  logic [ADDR_W-1:0]       e_addr [DEPTH];
  logic [AGE_W-1:0]        e_age  [DEPTH];
  logic [CYC_W-1:0]        e_done [DEPTH];

  logic [DEPTH-1:0]        done_w, opnd_ok, mem_blk, cand, sel;
  int                      n_cmt, n_enq, free_slots;

  // completion: issued and due cycle reached (wrap-safe)
  always_comb
    for (int k = 0; k < DEPTH; k++)
      done_w[k] = e_vld[k] && e_iss[k] && ($signed(cyc - e_done[k]) >= 0);

  always_comb
    for (int k = 0; k < DEPTH; k++) begin
      opnd_ok[k] = 1'b1;
      for (int s = 0; s < 3; s++)
        if (e_sv[k][s] && !preg_ready[e_src[k][s*PTAG_W +: PTAG_W]]) opnd_ok[k] = 1'b0;
    end

  generate
    if (MEM_MODE == 0) begin : g_mem_free
      assign mem_blk = '0;
    end else begin : g_mem_order
      always_comb
        for (int k = 0; k < DEPTH; k++) begin
          mem_blk[k] = 1'b0;
          for (int j = 0; j < DEPTH; j++)
            if (j != k && e_vld[j] && e_st[j] && !done_w[j] &&
                ($signed(e_age[j] - e_age[k]) < 0) &&
                (MEM_MODE == 1 || e_addr[j] == e_addr[k]))
              mem_blk[k] = 1'b1;
        end
    end
  endgenerate

  assign cand = e_vld & ~e_iss & opnd_ok & ~(e_ld & mem_blk);

  // retire from head, in order
  always_comb begin
    logic stop;
    logic [IDX_W-1:0] idx;
    stop = 1'b0;
    n_cmt = 0;
    cmt_valid = '0;
    cmt_dst = '0;
    cmt_dst_vld = '0;
    for (int o = 0; o < WIDTH; o++) begin
      idx = head + IDX_W'(o);
      if (!stop && done_w[idx]) begin
        cmt_valid[o] = 1'b1;
        cmt_dst[o*2*PTAG_W +: 2*PTAG_W] = e_dst[idx];
        cmt_dst_vld[o*2 +: 2] = e_dv[idx];
        n_cmt = n_cmt + 1;
      end else begin
        stop = 1'b1;
      end
    end
  end

  // oldest-first select
  always_comb begin
    int n;
    logic [IDX_W-1:0] idx;
    n = 0;
    sel = '0;
    iss_valid = '0;
    iss_dst = '0;
    iss_dst_vld = '0;
    iss_lat = '0;
    for (int o = 0; o < DEPTH; o++) begin
      idx = head + IDX_W'(o);
      if (cand[idx] && n < WIDTH) begin
        sel[idx] = 1'b1;
        iss_valid[n] = 1'b1;
        iss_dst[n*2*PTAG_W +: 2*PTAG_W] = e_dst[idx];
        iss_dst_vld[n*2 +: 2] = e_dv[idx];
        iss_lat[n*LAT_W +: LAT_W] = e_ld[idx] ? LAT_W'(LOAD_LAT) : LAT_W'(1);
        n = n + 1;
      end
    end
  end

  // accept at tail, after retirement frees slots
  always_comb begin
    logic run;
    run = 1'b1;
    n_enq = 0;
    free_slots = DEPTH - int'(cnt) + n_cmt;
    for (int i = 0; i < WIDTH; i++) begin
      run = run && enq_valid[i];
      enq_grant[i] = run && (i < free_slots);
      if (enq_grant[i]) n_enq = n_enq + 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      head     <= '0;
      tail_age <= '0;
      cnt      <= '0;
      cyc      <= '0;
      e_vld    <= '0;
      e_iss    <= '0;
    end else begin
      cyc  <= cyc + CYC_W'(1);
      head <= head + IDX_W'(n_cmt);
      cnt  <= cnt - AGE_W'(n_cmt) + AGE_W'(n_enq);
      tail_age <= tail_age + AGE_W'(n_enq);
      for (int o = 0; o < WIDTH; o++)
        if (cmt_valid[o]) e_vld[head + IDX_W'(o)] <= 1'b0;
      for (int k = 0; k < DEPTH; k++)
        if (sel[k]) begin
          e_iss[k]  <= 1'b1;
          e_done[k] <= cyc + (e_ld[k] ? CYC_W'(LOAD_LAT) : CYC_W'(1));
        end
      for (int i = 0; i < WIDTH; i++)
        if (enq_grant[i]) begin
          e_vld [tail_age[IDX_W-1:0] + IDX_W'(i)] <= 1'b1;
          e_iss [tail_age[IDX_W-1:0] + IDX_W'(i)] <= 1'b0;
          e_ld  [tail_age[IDX_W-1:0] + IDX_W'(i)] <= enq_load[i];
          e_st  [tail_age[IDX_W-1:0] + IDX_W'(i)] <= enq_store[i];
          e_src [tail_age[IDX_W-1:0] + IDX_W'(i)] <= enq_src[i*3*PTAG_W +: 3*PTAG_W];
          e_sv  [tail_age[IDX_W-1:0] + IDX_W'(i)] <= enq_src_vld[i*3 +: 3];
          e_dst [tail_age[IDX_W-1:0] + IDX_W'(i)] <= enq_dst[i*2*PTAG_W +: 2*PTAG_W];
          e_dv  [tail_age[IDX_W-1:0] + IDX_W'(i)] <= enq_dst_vld[i*2 +: 2];
          e_addr[tail_age[IDX_W-1:0] + IDX_W'(i)] <= enq_addr[i*ADDR_W +: ADDR_W];
          e_age [tail_age[IDX_W-1:0] + IDX_W'(i)] <= tail_age + AGE_W'(i);
        end
    end

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= AGE_W'(DEPTH));

  assert_full_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == AGE_W'(DEPTH) && !cmt_valid[0]) |-> (enq_grant == '0));

  assert_retire_issued_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid[0] |-> e_iss[head]);

  assert_issue_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid != '0) |=> (cnt != '0));

  generate
    for (genvar gi = 1; gi < WIDTH; gi++) begin : g_order_chk
      assert_retire_packed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_valid[gi] |-> cmt_valid[gi-1]);
      assert_issue_packed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid[gi] |-> iss_valid[gi-1]);
    end
  endgenerate
endmodule

// File: tb/uop_window_tb.sv
module uop_window_tb_top;
  localparam int DEPTH = 4, WIDTH = 2, PTAG_W = 4, ADDR_W = 8, CYC_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [WIDTH-1:0]          enq_valid, enq_load, enq_store;
  logic [WIDTH*3*PTAG_W-1:0] enq_src;
  logic [WIDTH*3-1:0]        enq_src_vld;
  logic [WIDTH*2*PTAG_W-1:0] enq_dst;
  logic [WIDTH*2-1:0]        enq_dst_vld;
  logic [WIDTH*ADDR_W-1:0]   enq_addr;
  logic [15:0]               preg_ready;

  logic [1:0]  gnt [3], ivl [3], cvl [3];
  logic [15:0] idst [3], cdst [3];
  logic [3:0]  idv [3], cdv [3], ilat [3];

  uop_window #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PTAG_W(PTAG_W), .ADDR_W(ADDR_W), .CYC_W(CYC_W), .MEM_MODE(0)) dut_i (
    .clk, .rst_n, .enq_valid, .enq_src, .enq_src_vld, .enq_dst, .enq_dst_vld, .enq_load, .enq_store, .enq_addr, .preg_ready,
    .enq_grant(gnt[0]), .iss_valid(ivl[0]), .iss_dst(idst[0]), .iss_dst_vld(idv[0]), .iss_lat(ilat[0]),
    .cmt_valid(cvl[0]), .cmt_dst(cdst[0]), .cmt_dst_vld(cdv[0]));
  uop_window #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PTAG_W(PTAG_W), .ADDR_W(ADDR_W), .CYC_W(CYC_W), .MEM_MODE(1)) dut_cons (
    .clk, .rst_n, .enq_valid, .enq_src, .enq_src_vld, .enq_dst, .enq_dst_vld, .enq_load, .enq_store, .enq_addr, .preg_ready,
    .enq_grant(gnt[1]), .iss_valid(ivl[1]), .iss_dst(idst[1]), .iss_dst_vld(idv[1]), .iss_lat(ilat[1]),
    .cmt_valid(cvl[1]), .cmt_dst(cdst[1]), .cmt_dst_vld(cdv[1]));
  uop_window #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PTAG_W(PTAG_W), .ADDR_W(ADDR_W), .CYC_W(CYC_W), .MEM_MODE(2)) dut_exact (
    .clk, .rst_n, .enq_valid, .enq_src, .enq_src_vld, .enq_dst, .enq_dst_vld, .enq_load, .enq_store, .enq_addr, .preg_ready,
    .enq_grant(gnt[2]), .iss_valid(ivl[2]), .iss_dst(idst[2]), .iss_dst_vld(idv[2]), .iss_lat(ilat[2]),
    .cmt_valid(cvl[2]), .cmt_dst(cdst[2]), .cmt_dst_vld(cdv[2]));

  int errors = 0, checks = 0;

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic clear_in();
    enq_valid = '0; enq_load = '0; enq_store = '0; enq_src = '0; enq_src_vld = '0;
    enq_dst = '0; enq_dst_vld = '0; enq_addr = '0;
  endtask

  task automatic set_uop(input int slot, input logic [3:0] s0, input logic [3:0] s1, input logic [2:0] sv,
                         input logic [3:0] d0, input logic [1:0] dv, input logic ld, input logic st,
                         input logic [7:0] addr);
    enq_valid[slot] = 1'b1;
    enq_src[(3*slot)*PTAG_W +: PTAG_W] = s0;
    enq_src[(3*slot+1)*PTAG_W +: PTAG_W] = s1;
    enq_src[(3*slot+2)*PTAG_W +: PTAG_W] = '0;
    enq_src_vld[3*slot +: 3] = sv;
    enq_dst[(2*slot)*PTAG_W +: PTAG_W] = d0;
    enq_dst[(2*slot+1)*PTAG_W +: PTAG_W] = '0;
    enq_dst_vld[2*slot +: 2] = dv;
    enq_load[slot] = ld;
    enq_store[slot] = st;
    enq_addr[slot*ADDR_W +: ADDR_W] = addr;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    clear_in();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // row: en[31:30] tag0[29:26] tag1[25:22] ready[21:6] grant[5:4] issue[3:2] commit[1:0]
  localparam logic [31:0] TBL [6] = '{
    {2'b11, 4'd1, 4'd2, 16'hFFFF, 2'b11, 2'b00, 2'b00},
    {2'b11, 4'd3, 4'd4, 16'hFFFB, 2'b11, 2'b01, 2'b00},
    {2'b11, 4'd5, 4'd6, 16'hFFFF, 2'b01, 2'b11, 2'b01},
    {2'b11, 4'd6, 4'd7, 16'hFFEF, 2'b11, 2'b01, 2'b11},
    {2'b00, 4'd0, 4'd0, 16'hFFFF, 2'b00, 2'b11, 2'b00},
    {2'b11, 4'd8, 4'd9, 16'hFFFF, 2'b11, 2'b01, 2'b11}
  };

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    preg_ready = '1;
    do_reset();

    // R11 / R1: idle after reset, grant rules (nothing latched)
    enq_valid = 2'b10; #1;
    chk("R1 gap slot0 blocks slot1", gnt[0], 0);
    chk("R11 no issue after reset", ivl[0], 0);
    chk("R11 no commit after reset", cvl[0], 0);
    enq_valid = 2'b01; #1;
    chk("R11 grant slot0 on empty", gnt[0], 1);
    enq_valid = 2'b00;
    @(negedge clk);

    // table: oldest-first, same-cycle refill, R6 no same-cycle issue
    for (int r = 0; r < 6; r++) begin
      clear_in();
      preg_ready = TBL[r][21:6];
      if (TBL[r][31]) set_uop(1, TBL[r][25:22], 4'd0, 3'b001, TBL[r][25:22] + 4'd8, 2'b01, 1'b0, 1'b0, 8'd0);
      if (TBL[r][30]) set_uop(0, TBL[r][29:26], 4'd0, 3'b001, TBL[r][29:26] + 4'd8, 2'b01, 1'b0, 1'b0, 8'd0);
      #1;
      chk($sformatf("R1 table grant row %0d", r), gnt[0], TBL[r][5:4]);
      chk($sformatf("R4 R5 R6 table issue row %0d", r), ivl[0], TBL[r][3:2]);
      chk($sformatf("R2 R3 table commit row %0d", r), cvl[0], TBL[r][1:0]);
      @(negedge clk);
    end

    // full window, grant after same-cycle retirement
    do_reset();
    preg_ready = '0;
    for (int c = 0; c < 5; c++) begin
      clear_in();
      if (c == 3) preg_ready = '1;
      set_uop(0, 4'd15, 4'd0, 3'b001, 4'(2*c+1), 2'b01, 1'b0, 1'b0, 8'd0);
      set_uop(1, 4'd15, 4'd0, 3'b001, 4'(2*c+2), 2'b01, 1'b0, 1'b0, 8'd0);
      #1;
      if (c < 2) chk("R1 grant while space", gnt[0], 3);
      if (c == 2) begin
        chk("R1 full window grants nothing", gnt[0], 0);
        chk("R5 operand not ready blocks issue", ivl[0], 0);
      end
      if (c == 3) begin
        chk("R1 still full without retirement", gnt[0], 0);
        chk("R4 two oldest selected", ivl[0], 3);
        chk("R4 slot0 is oldest", idst[0][3:0], 1);
      end
      if (c == 4) begin
        chk("R1 refill of slots retired this cycle", gnt[0], 3);
        chk("R12 commit tags slot0", cdst[0][3:0], 1);
        chk("R12 commit tags slot1", cdst[0][11:8], 2);
        chk("R12 commit dst valid", cdv[0], 4'b0101);
      end
      @(negedge clk);
    end

    // memory ordering on three rules, ages wrap (store 7, loads 0 and 1)
    do_reset();
    preg_ready = 16'hFBFF;
    for (int t = 0; t < 11; t++) begin
      clear_in();
      if (t < 3) begin
        set_uop(0, 4'd1, 4'd0, 3'b001, 4'd2, 2'b01, 1'b0, 1'b0, 8'd0);
        set_uop(1, 4'd1, 4'd0, 3'b001, 4'd3, 2'b01, 1'b0, 1'b0, 8'd0);
      end
      if (t == 3) begin
        set_uop(0, 4'd1, 4'd10, 3'b001, 4'd11, 2'b01, 1'b0, 1'b0, 8'd0);
        set_uop(1, 4'd10, 4'd0, 3'b001, 4'd0, 2'b00, 1'b0, 1'b1, 8'h40);
      end
      if (t == 4) begin
        set_uop(0, 4'd1, 4'd0, 3'b001, 4'd12, 2'b01, 1'b1, 1'b0, 8'h40);
        set_uop(1, 4'd1, 4'd0, 3'b001, 4'd13, 2'b01, 1'b1, 1'b0, 8'h44);
      end
      if (t >= 6) preg_ready = '1;
      #1;
      case (t)
        4: begin
          chk("R5 invalid source ignored", ivl[0], 1);
          chk("R12 issue dst tag", idst[0][3:0], 11);
          chk("R3 non-load latency", ilat[0][1:0], 1);
        end
        5: begin
          chk("R7 loads pass unissued store", ivl[0], 3);
          chk("R3 load latency slot0", ilat[0][1:0], 3);
          chk("R3 load latency slot1", ilat[0][3:2], 3);
          chk("R12 load dst tag", idst[0][3:0], 12);
          chk("R8 loads held by older store", ivl[1], 0);
          chk("R9 R10 only other-address load issues", ivl[2], 1);
          chk("R9 R10 issued load is the 0x44 one", idst[2][3:0], 13);
          chk("R2 retire X in all rules", cvl[0] + cvl[1] + cvl[2], 3);
        end
        6: begin
          chk("R8 store issues alone", ivl[1], 1);
          chk("R3 store latency", ilat[1][1:0], 1);
          chk("R9 load still held by issued store", ivl[2], 1);
          chk("R2 head store not complete", cvl[1], 0);
        end
        7: begin
          chk("R8 loads issue once store complete", ivl[1], 3);
          chk("R9 same-address load issues", ivl[2], 1);
          chk("R9 it is the 0x40 load", idst[2][3:0], 12);
          chk("R7 nothing left to issue", ivl[0], 0);
          chk("R3 store retires one cycle after issue", cvl[1], 1);
        end
        8: begin
          chk("R3 loads retire three cycles after issue", cvl[0], 3);
          chk("R12 retire tag slot1", cdst[0][11:8], 13);
          chk("R2 younger complete load waits behind head", cvl[2], 0);
          chk("R3 load not complete early", cvl[1], 0);
        end
        10: begin
          chk("R3 conservative loads retire", cvl[1], 3);
          chk("R2 both retire together", cvl[2], 3);
        end
        default: ;
      endcase
      @(negedge clk);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule